// File: doc/BRIEF.md
# Portable Pixel Stream Output Stage

This block turns 4-bit-per-channel paint values into a registered pixel stream for a consumer that fills a frame buffer in memory, rather than driving monitor pins. A two-bit free-running counter on the system clock sets the pixel rate. Its top bit is the pixel clock, at one quarter of the system frequency, and no PLL is needed. Horizontal and vertical counters walk a standard 480p raster: 640 by 480 visible, 800 by 525 in total.

On every pixel-clock edge the block registers the raster position, an active-video flag, the paint widened to 8 bits per channel, and sync levels. A frame-done flag marks the first pixel of the vertical blanking region. The consumer stores each pixel whose active flag is set at the reported coordinate. It uses the frame-done flag to hand the finished picture on, once per frame.

All outputs are registered in the system clock domain and change only on the edge where the pixel clock rises. Reset is synchronous and active high.

Top module: `pix_stream_out`

## Requirements
- R1: `pix_clk` is the most significant bit of a two-bit counter that increments on every system clock edge. It rises once every 4 system cycles, and the registered pixel outputs change only on the system edge where it rises.
- R2: On each pixel edge, `px_x`/`px_y` (10 bits) report the raster position held before that edge. The position then advances by one along x.
- R3: `px_de` is 1 exactly when the reported position has x < 640 and y < 480.
- R4: Each output colour channel is its 4-bit paint input sampled at the pixel edge and repeated twice: paint 0xA gives 0xAA. Red, green and blue are independent.
- R5: `px_hsync_n` is 0 for reported x from 656 to 751 inclusive, and 1 otherwise. `px_vsync_n` is 0 for reported y of 490 and 491, and 1 otherwise.
- R6: After x = 799 the position goes to x = 0 with y + 1. After (799, 524) it goes to (0, 0).
- R7: `frame_done` is 1 for exactly one pixel period, the one whose reported position is (0, 480), so it rises once per frame.
- R8: While `rst` is 1 at a clock edge, the block clears the divider and both counters. The outputs become x = 0, y = 0, `px_de` 0, colours 0, both syncs 1, `frame_done` 0 and `pix_clk` 0. The first pixel reported after `rst` falls is (0, 0), on the second system edge after release.
- R9: Paint changes between pixel edges are not visible at the outputs until the next pixel edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| paint_r | input | 4 | Red paint value |
| paint_g | input | 4 | Green paint value |
| paint_b | input | 4 | Blue paint value |
| pix_clk | output | 1 | Pixel clock, quarter rate, divider MSB |
| px_x | output | 10 | Registered x coordinate |
| px_y | output | 10 | Registered y coordinate |
| px_de | output | 1 | Registered active-video flag |
| px_r | output | 8 | Registered widened red |
| px_g | output | 8 | Registered widened green |
| px_b | output | 8 | Registered widened blue |
| px_hsync_n | output | 1 | Registered horizontal sync, active low |
| px_vsync_n | output | 1 | Registered vertical sync, active low |
| frame_done | output | 1 | One-pixel flag at the start of vertical blanking |

## Verification
A divider stuck in the wrong phase shows within four system cycles after reset: the first pixel arrives on the wrong edge, or `pix_clk` breaks its 1-0-0-1 pattern. A counter that misses a wrap or a bound shows as a wrong `px_x` on the very next pixel. At the scale of a full line, the same fault appears as a wrong `px_de` or sync level at the 640, 656 or 752 columns. Vertical faults and a doubled or missing `frame_done` need a full frame to appear. A second instance with a reduced raster brings those into a few hundred pixels.

// File: rtl/pix_stream_pkg.sv
package pix_stream_pkg;

  localparam int NCH = 3;

  function automatic logic in_span(input int v, input int lo, input int hi);
    return (v >= lo) && (v < hi);
  endfunction

endpackage

// File: rtl/pix_clk_div.sv
module pix_clk_div #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst,
  output logic pix_clk,
  output logic pix_ce
);

  localparam logic [DIV_W-1:0] PRE_RISE = {1'b0, {(DIV_W-1){1'b1}}};

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign pix_clk = div_q[DIV_W-1];
  // strobe on the edge where the MSB is about to rise
  assign pix_ce  = (div_q == PRE_RISE);

  p_ce_rise_r1: assert property (@(posedge clk) disable iff (rst)
    pix_ce |=> (pix_clk && !$past(pix_clk)));

  p_msb_only_rises_on_ce_r1: assert property (@(posedge clk) disable iff (rst)
    !pix_ce |=> !$rose(pix_clk));

endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import pix_stream_pkg::*;
#(
  parameter int CW       = 10,
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  output logic [CW-1:0] x,
  output logic [CW-1:0] y,
  output logic          de,
  output logic          hs_act,
  output logic          vs_act,
  output logic          fmark
);

  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HS_LO   = H_ACTIVE + H_FP;
  localparam int HS_HI   = HS_LO + H_SYNC;
  localparam int VS_LO   = V_ACTIVE + V_FP;
  localparam int VS_HI   = VS_LO + V_SYNC;
  localparam logic [CW-1:0] X_LAST = CW'(H_TOTAL - 1);
  localparam logic [CW-1:0] Y_LAST = CW'(V_TOTAL - 1);
  localparam logic [CW-1:0] Y_BLANK = CW'(V_ACTIVE);

  logic [CW-1:0] x_q, y_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (ce) begin
      if (x_q == X_LAST) begin
        x_q <= '0;
        if (y_q == Y_LAST) y_q <= '0;
        else               y_q <= y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  assign x      = x_q;
  assign y      = y_q;
  assign de     = in_span(int'(x_q), 0, H_ACTIVE) && in_span(int'(y_q), 0, V_ACTIVE);
  assign hs_act = in_span(int'(x_q), HS_LO, HS_HI);
  assign vs_act = in_span(int'(y_q), VS_LO, VS_HI);
  assign fmark  = (x_q == '0) && (y_q == Y_BLANK);

  p_x_step_r2: assert property (@(posedge clk) disable iff (rst)
    (ce && x_q != X_LAST) |=> (x_q == $past(x_q) + 1'b1) && (y_q == $past(y_q)));

  p_x_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (ce && x_q == X_LAST) |=> (x_q == '0));

  p_y_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (ce && x_q == X_LAST && y_q == Y_LAST) |=> (y_q == '0));

  p_bounds_r2: assert property (@(posedge clk) disable iff (rst)
    (x_q <= X_LAST) && (y_q <= Y_LAST));

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(x_q) && $stable(y_q));

endmodule

// File: rtl/pix_out_reg.sv
module pix_out_reg
  import pix_stream_pkg::*;
#(
  parameter int CW       = 10,
  parameter int IN_W     = 4,
  parameter int OUT_W    = 8,
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ce,
  input  logic [CW-1:0]              x,
  input  logic [CW-1:0]              y,
  input  logic                       de,
  input  logic                       hs_act,
  input  logic                       vs_act,
  input  logic                       fmark,
  input  logic [NCH-1:0][IN_W-1:0]   paint,
  output logic [CW-1:0]              x_o,
  output logic [CW-1:0]              y_o,
  output logic                       de_o,
  output logic [NCH-1:0][OUT_W-1:0]  rgb_o,
  output logic                       hsync_n_o,
  output logic                       vsync_n_o,
  output logic                       fdone_o
);

  localparam int REP = OUT_W / IN_W;

  logic [CW-1:0]             x_q, y_q;
  logic                      de_q, hs_q, vs_q, fd_q;
  logic [NCH-1:0][OUT_W-1:0] rgb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q  <= '0;
      y_q  <= '0;
      de_q <= 1'b0;
      hs_q <= 1'b1;
      vs_q <= 1'b1;
      fd_q <= 1'b0;
    end else if (ce) begin
      x_q  <= x;
      y_q  <= y;
      de_q <= de;
      hs_q <= ~hs_act;
      vs_q <= ~vs_act;
      fd_q <= fmark;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst)     rgb_q[c] <= '0;
      else if (ce) rgb_q[c] <= {REP{paint[c]}};
    end
  end

  assign x_o       = x_q;
  assign y_o       = y_q;
  assign de_o      = de_q;
  assign rgb_o     = rgb_q;
  assign hsync_n_o = hs_q;
  assign vsync_n_o = vs_q;
  assign fdone_o   = fd_q;

  p_de_region_r3: assert property (@(posedge clk) disable iff (rst)
    de_q |-> (x_q < CW'(H_ACTIVE)) && (y_q < CW'(V_ACTIVE)));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(rgb_q) && $stable(x_q) && $stable(de_q) && $stable(fd_q));

  p_frame_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (fd_q && ce) |=> !fd_q);

  p_frame_origin_r7: assert property (@(posedge clk) disable iff (rst)
    fd_q |-> (x_q == '0) && (y_q == CW'(V_ACTIVE)) && !de_q);

endmodule

// File: rtl/pix_stream_out.sv
module pix_stream_out
  import pix_stream_pkg::*;
#(
  parameter int COORD_W  = 10,
  parameter int DIV_W    = 2,
  parameter int IN_W     = 4,
  parameter int OUT_W    = 8,
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IN_W-1:0]    paint_r,
  input  logic [IN_W-1:0]    paint_g,
  input  logic [IN_W-1:0]    paint_b,
  output logic               pix_clk,
  output logic [COORD_W-1:0] px_x,
  output logic [COORD_W-1:0] px_y,
  output logic               px_de,
  output logic [OUT_W-1:0]   px_r,
  output logic [OUT_W-1:0]   px_g,
  output logic [OUT_W-1:0]   px_b,
  output logic               px_hsync_n,
  output logic               px_vsync_n,
  output logic               frame_done
);

  logic                      pix_ce;
  logic [COORD_W-1:0]        cx, cy;
  logic                      c_de, c_hs, c_vs, c_fm;
  logic [NCH-1:0][IN_W-1:0]  paint;
  logic [NCH-1:0][OUT_W-1:0] rgb;

  assign paint = {paint_b, paint_g, paint_r};

  pix_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .pix_clk (pix_clk),
    .pix_ce  (pix_ce)
  );

  raster_timer #(
    .CW(COORD_W), .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_raster (
    .clk    (clk),
    .rst    (rst),
    .ce     (pix_ce),
    .x      (cx),
    .y      (cy),
    .de     (c_de),
    .hs_act (c_hs),
    .vs_act (c_vs),
    .fmark  (c_fm)
  );

  pix_out_reg #(
    .CW(COORD_W), .IN_W(IN_W), .OUT_W(OUT_W), .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .ce        (pix_ce),
    .x         (cx),
    .y         (cy),
    .de        (c_de),
    .hs_act    (c_hs),
    .vs_act    (c_vs),
    .fmark     (c_fm),
    .paint     (paint),
    .x_o       (px_x),
    .y_o       (px_y),
    .de_o      (px_de),
    .rgb_o     (rgb),
    .hsync_n_o (px_hsync_n),
    .vsync_n_o (px_vsync_n),
    .fdone_o   (frame_done)
  );

  assign px_r = rgb[0];
  assign px_g = rgb[1];
  assign px_b = rgb[2];

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (px_x == '0) && (px_y == '0) && !px_de && !frame_done && !pix_clk);

endmodule

// File: tb/tb_pix_stream_out.sv
module tb_pix_stream_out;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] pr = 4'h0, pg = 4'h0, pb = 4'h0;

  always #5 clk = ~clk;

  logic       pc_a, de_a, hs_a, vs_a, fd_a;
  logic [9:0] x_a, y_a;
  logic [7:0] r_a, g_a, b_a;
  logic       pc_b, de_b, hs_b, vs_b, fd_b;
  logic [9:0] x_b, y_b;
  logic [7:0] r_b, g_b, b_b;

  pix_stream_out dut (
    .clk(clk), .rst(rst), .paint_r(pr), .paint_g(pg), .paint_b(pb),
    .pix_clk(pc_a), .px_x(x_a), .px_y(y_a), .px_de(de_a),
    .px_r(r_a), .px_g(g_a), .px_b(b_a),
    .px_hsync_n(hs_a), .px_vsync_n(vs_a), .frame_done(fd_a)
  );

  // reduced raster: 16 x 8 total, 8 x 4 visible
  pix_stream_out #(
    .H_ACTIVE(8), .H_FP(2), .H_SYNC(3), .H_BP(3),
    .V_ACTIVE(4), .V_FP(1), .V_SYNC(2), .V_BP(1)
  ) dut_s (
    .clk(clk), .rst(rst), .paint_r(pr), .paint_g(pg), .paint_b(pb),
    .pix_clk(pc_b), .px_x(x_b), .px_y(y_b), .px_de(de_b),
    .px_r(r_b), .px_g(g_b), .px_b(b_b),
    .px_hsync_n(hs_b), .px_vsync_n(vs_b), .frame_done(fd_b)
  );

  int checks = 0;
  int errors = 0;
  int n = 0;
  bit done = 0;

  // paint in, widened out
  localparam logic [35:0] TBL [8] = '{
    {4'hA, 4'h0, 4'hF, 8'hAA, 8'h00, 8'hFF},
    {4'h1, 4'h2, 4'h3, 8'h11, 8'h22, 8'h33},
    {4'hF, 4'hF, 4'hF, 8'hFF, 8'hFF, 8'hFF},
    {4'h0, 4'h0, 4'h0, 8'h00, 8'h00, 8'h00},
    {4'h5, 4'hA, 4'hC, 8'h55, 8'hAA, 8'hCC},
    {4'h8, 4'h7, 4'hE, 8'h88, 8'h77, 8'hEE},
    {4'h3, 4'h9, 4'h6, 8'h33, 8'h99, 8'h66},
    {4'hE, 4'h1, 4'hB, 8'hEE, 8'h11, 8'hBB}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (pixel %0d)", tag, act, exp, n);
    end
  endtask

  task automatic wait_pix();
    @(posedge pc_a);
    #1;
  endtask

  task automatic check_reset_state();
    chk("R8 reset x", int'(x_a), 0);
    chk("R8 reset y", int'(y_a), 0);
    chk("R8 reset de", int'(de_a), 0);
    chk("R8 reset rgb", int'({r_a, g_a, b_a}), 0);
    chk("R8 reset hsync", int'(hs_a), 1);
    chk("R8 reset vsync", int'(vs_a), 1);
    chk("R8 reset frame_done", int'(fd_a), 0);
    chk("R8 reset pix_clk", int'(pc_a), 0);
    chk("R8 reset small x", int'(x_b), 0);
  endtask

  task automatic check_px();
    int xa, ya, xb, yb;
    xa = n % 800;  ya = (n / 800) % 525;
    xb = n % 16;   yb = (n / 16) % 8;
    chk("R2 x", int'(x_a), xa);
    chk("R2 y", int'(y_a), ya);
    chk("R3 de", int'(de_a), int'(xa < 640 && ya < 480));
    chk("R5 hsync", int'(hs_a), int'(!(xa >= 656 && xa < 752)));
    chk("R5 vsync", int'(vs_a), int'(!(ya >= 490 && ya < 492)));
    chk("R7 frame_done", int'(fd_a), int'(xa == 0 && ya == 480));
    chk("R4 red", int'(r_a), int'({pr, pr}));
    chk("R4 green", int'(g_a), int'({pg, pg}));
    chk("R4 blue", int'(b_a), int'({pb, pb}));
    chk("R6 small x", int'(x_b), xb);
    chk("R6 small y", int'(y_b), yb);
    chk("R3 small de", int'(de_b), int'(xb < 8 && yb < 4));
    chk("R5 small hsync", int'(hs_b), int'(!(xb >= 10 && xb < 13)));
    chk("R5 small vsync", int'(vs_b), int'(!(yb >= 5 && yb < 7)));
    chk("R7 small frame_done", int'(fd_b), int'(xb == 0 && yb == 4));
    n++;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int fd_count;
    logic [3:0] or_q;
    logic [9:0] ox;
    repeat (3) @(posedge clk);
    #1;
    check_reset_state();

    // release; first pixel on the second system edge (R8)
    pr = 4'hA; pg = 4'h0; pb = 4'hF;
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    chk("R8 no pixel on first edge", int'(pc_a), 0);
    chk("R8 de still low", int'(de_a), 0);
    @(posedge clk); #1;
    chk("R8 first pixel pix_clk", int'(pc_a), 1);
    n = 0;
    check_px();

    // divider pattern after first pixel edge: 1,0,0,1 (R1)
    @(posedge clk); #1; chk("R1 phase 1", int'(pc_a), 1);
    chk("R1 no update off edge", int'(x_a), 0);
    @(posedge clk); #1; chk("R1 phase 2", int'(pc_a), 0);
    @(posedge clk); #1; chk("R1 phase 3", int'(pc_a), 0);
    @(posedge clk); #1; chk("R1 phase 4", int'(pc_a), 1);
    check_px();

    // R9: paint change between edges stays hidden
    or_q = pr; ox = x_a;
    pr = 4'h3;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R9 red held", int'(r_a), int'({or_q, or_q}));
    chk("R9 x held", int'(x_a), int'(ox));
    wait_pix();
    check_px();

    // table of paint vectors (R4)
    for (int i = 0; i < 8; i++) begin
      {pr, pg, pb} = TBL[i][35:24];
      wait_pix();
      chk("R4 table red", int'(r_a), int'(TBL[i][23:16]));
      chk("R4 table green", int'(g_a), int'(TBL[i][15:8]));
      chk("R4 table blue", int'(b_a), int'(TBL[i][7:0]));
      check_px();
    end

    // long stream: full line of default raster, several small frames
    fd_count = 0;
    for (int k = 0; k < 1000; k++) begin
      pr = 4'(k); pg = 4'(~k); pb = 4'(k >> 4);
      wait_pix();
      if (fd_b) fd_count++;
      check_px();
    end
    // pixels 11..1010: small frame starts at 64+128m -> 64..960 gives 8
    chk("R7 small frame count", fd_count, 8);

    // mid-run reset (R8)
    #2;
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check_reset_state();
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    chk("R8 restart no pixel yet", int'(pc_a), 0);
    @(posedge clk); #1;
    n = 0;
    check_px();
    for (int k = 0; k < 20; k++) begin
      wait_pix();
      check_px();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule